// File: doc/BRIEF.md
# Double-Precision Compare Flag Generator

This block compares two 64-bit binary64 words and reports the outcome as four condition flags, packed as `{N, Z, C, V}`, together with an invalid-operation flag. It works on the raw bit patterns and does not unpack the operands. Two words with the same sign are ordered as unsigned integers, and that order is reversed when both are negative. Two words with opposite signs are ordered by sign alone. Positive zero and negative zero compare equal.

A mode input picks quiet or signalling behaviour. In quiet mode, only a signalling NaN (top mantissa bit 0) raises invalid. In signalling mode, any NaN raises invalid. A second input replaces the second operand with positive zero, which gives the compare-against-zero forms. The decision logic is combinational. A parameter adds a registered output stage with synchronous active-high reset, and that stage is present by default.

Top module: `dcmp_flags`

## Requirements
- R1: A word is a NaN when bits [62:52] are all ones and bits [51:0] are not all zero. If either effective operand is a NaN, the flags are unordered, `4'b0011` (C and V set).
- R2: In quiet mode (`sig_mode`=0), invalid is 1 only when an effective operand is a NaN with bit 51 clear. A NaN with bit 51 set gives unordered flags with invalid 0.
- R3: In signalling mode (`sig_mode`=1), any NaN operand raises invalid.
- R4: Bitwise-identical non-NaN operands, or a pair that are both zeros of either sign, give equal, `4'b0110` (Z and C set).
- R5: For non-equal operands with different signs (bit 63), the one with bit 63 set is the smaller.
- R6: For non-equal operands that are both non-negative, the smaller unsigned bit pattern is smaller. Less-than gives `4'b1000` (only N) and greater-than gives `4'b0010` (only C).
- R7: For non-equal operands that are both negative, the larger unsigned bit pattern is smaller.
- R8: When `zero_cmp`=1, the second operand is treated as +0 (all bits zero) and the value on `op_b` has no effect.
- R9: With `REG_OUT`=1, the flags and invalid for inputs applied before a rising clock edge appear on the outputs after that edge. Reset clears both outputs to zero.
- R10: A comparison with no NaN never raises invalid, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| sig_mode | input | 1 | 1 = signalling compare, 0 = quiet compare |
| zero_cmp | input | 1 | 1 = compare op_a against +0 |
| flags_o | output | 4 | Condition flags {N, Z, C, V} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
In the default build, every result is due one clock after its operands are applied: inputs set up before a rising edge show up on the outputs after that edge. The driver changes inputs on the falling edge and queues the expected flags at the same moment. The monitor pops and compares the queue five nanoseconds after each rising edge, so each comparison lands on exactly the edge that captured its operands. The assertions use the same one-cycle offset, relating inputs in one cycle to outputs in the next.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    localparam int WORD_W = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } cmp_rel_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } fp_class_t;

    // flag codes, packed {N, Z, C, V}
    localparam logic [FLAG_W-1:0] FLAGS_LT = 4'b1000;
    localparam logic [FLAG_W-1:0] FLAGS_EQ = 4'b0110;
    localparam logic [FLAG_W-1:0] FLAGS_GT = 4'b0010;
    localparam logic [FLAG_W-1:0] FLAGS_UN = 4'b0011;

    function automatic logic [FLAG_W-1:0] rel_to_flags(cmp_rel_t r);
        case (r)
            REL_LT:  return FLAGS_LT;
            REL_EQ:  return FLAGS_EQ;
            REL_GT:  return FLAGS_GT;
            default: return FLAGS_UN;
        endcase
    endfunction

endpackage

// File: rtl/dcmp_classify.sv
module dcmp_classify
    import dcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fp_class_t         cls_o
);
    fp_word_t w;
    logic     exp_ones;
    logic     frac_nz;

    always_comb begin
        w              = fp_word_t'(word_i);
        exp_ones       = &w.expo;
        frac_nz        = |w.frac;
        cls_o.is_nan   = exp_ones && frac_nz;
        cls_o.is_snan  = exp_ones && frac_nz && !w.frac[FRAC_W-1];
        cls_o.is_zero  = (w.expo == '0) && !frac_nz;
        cls_o.sign     = w.sign;
    end
endmodule

// File: rtl/dcmp_order.sv
module dcmp_order
    import dcmp_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  fp_class_t         a_cls,
    input  fp_class_t         b_cls,
    output cmp_rel_t          rel_o
);
    logic same_bits;
    logic both_zero;
    logic mag_below;

    always_comb begin
        same_bits = (a_i == b_i);
        both_zero = a_cls.is_zero && b_cls.is_zero;
        mag_below = a_i[WORD_W-2:0] < b_i[WORD_W-2:0];
        if (same_bits || both_zero)
            rel_o = REL_EQ;
        else if (a_cls.sign != b_cls.sign)
            rel_o = a_cls.sign ? REL_LT : REL_GT;
        else if (mag_below ^ a_cls.sign)
            rel_o = REL_LT;
        else
            rel_o = REL_GT;
    end
endmodule

// File: rtl/dcmp_encode.sv
module dcmp_encode
    import dcmp_pkg::*;
(
    input  cmp_rel_t          ord_rel_i,
    input  fp_class_t         a_cls,
    input  fp_class_t         b_cls,
    input  logic              sig_mode_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              invalid_o
);
    logic     any_nan;
    logic     any_snan;
    cmp_rel_t rel;

    always_comb begin
        any_nan   = a_cls.is_nan  || b_cls.is_nan;
        any_snan  = a_cls.is_snan || b_cls.is_snan;
        rel       = any_nan ? REL_UN : ord_rel_i;
        flags_o   = rel_to_flags(rel);
        invalid_o = any_snan || (sig_mode_i && any_nan);
    end
endmodule

// File: rtl/dcmp_flags.sv
module dcmp_flags
    import dcmp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sig_mode,
    input  logic              zero_cmp,
    output logic [FLAG_W-1:0] flags_o,
    output logic              invalid_o
);
    localparam int NUM_OPS = 2;

    logic [WORD_W-1:0] opnd [NUM_OPS];
    fp_class_t         cls  [NUM_OPS];
    cmp_rel_t          ord_rel;
    logic [FLAG_W-1:0] flags_c;
    logic              invalid_c;

    always_comb begin
        opnd[0] = op_a;
        opnd[1] = zero_cmp ? '0 : op_b;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        dcmp_classify u_cls (
            .word_i (opnd[i]),
            .cls_o  (cls[i])
        );
    end

    dcmp_order u_order (
        .a_i   (opnd[0]),
        .b_i   (opnd[1]),
        .a_cls (cls[0]),
        .b_cls (cls[1]),
        .rel_o (ord_rel)
    );

    dcmp_encode u_enc (
        .ord_rel_i  (ord_rel),
        .a_cls      (cls[0]),
        .b_cls      (cls[1]),
        .sig_mode_i (sig_mode),
        .flags_o    (flags_c),
        .invalid_o  (invalid_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o   <= '0;
                invalid_o <= 1'b0;
            end else begin
                flags_o   <= flags_c;
                invalid_o <= invalid_c;
            end
        end
    end else begin : g_comb
        always_comb begin
            flags_o   = flags_c;
            invalid_o = invalid_c;
        end
    end
endmodule

// File: rtl/dcmp_checker.sv
module dcmp_checker
    import dcmp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              sig_mode,
    input logic              zero_cmp,
    input logic [FLAG_W-1:0] flags_o,
    input logic              invalid_o
);
    logic a_nan, b_nan, b_eff_nan, a_zero;

    always_comb begin
        a_nan     = (&op_a[62:52]) && (|op_a[51:0]);
        b_nan     = (&op_b[62:52]) && (|op_b[51:0]);
        b_eff_nan = b_nan && !zero_cmp;
        a_zero    = (op_a[62:0] == '0);
    end

    if (REG_OUT) begin : g_chk
        // R1: NaN first operand gives unordered one cycle later
        assert_nan_unordered_R1: assert property (@(posedge clk) disable iff (rst)
            a_nan |=> (flags_o == FLAGS_UN));

        // R3: signalling mode with any NaN raises invalid
        assert_sig_mode_invalid_R3: assert property (@(posedge clk) disable iff (rst)
            (sig_mode && (a_nan || b_eff_nan)) |=> invalid_o);

        // R4: identical non-NaN words compare equal
        assert_same_equal_R4: assert property (@(posedge clk) disable iff (rst)
            (!zero_cmp && op_a == op_b && !a_nan) |=> (flags_o == FLAGS_EQ));

        // R8: a zero against the forced zero is equal
        assert_zero_cmp_R8: assert property (@(posedge clk) disable iff (rst)
            (zero_cmp && a_zero) |=> (flags_o == FLAGS_EQ && !invalid_o));

        // R10: no NaN means no invalid
        assert_no_nan_valid_R10: assert property (@(posedge clk) disable iff (rst)
            (!a_nan && !b_eff_nan) |=> !invalid_o);

        // R6: outputs after a live cycle are one of the four legal codes
        assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (flags_o == FLAGS_LT || flags_o == FLAGS_EQ ||
                      flags_o == FLAGS_GT || flags_o == FLAGS_UN));

        // R9: reset clears the output stage
        assert_reset_clear_R9: assert property (@(posedge clk)
            rst |=> (flags_o == '0 && !invalid_o));
    end
endmodule

bind dcmp_flags dcmp_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .sig_mode  (sig_mode),
    .zero_cmp  (zero_cmp),
    .flags_o   (flags_o),
    .invalid_o (invalid_o)
);

// File: tb/dcmp_flags_tb.sv
module dcmp_flags_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        sig_mode = 1'b0;
    logic        zero_cmp = 1'b0;
    logic [3:0]  flags_o;
    logic        invalid_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [3:0] flags;
        logic       inv;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    localparam logic [63:0] P0   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N0   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] P2   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] M1   = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] M2   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] MINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;

    always #10 clk = ~clk;

    dcmp_flags u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .sig_mode  (sig_mode),
        .zero_cmp  (zero_cmp),
        .flags_o   (flags_o),
        .invalid_o (invalid_o)
    );

    function automatic logic is_nan(logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    // monotone ordering key: larger key = larger value
    function automatic logic [63:0] okey(logic [63:0] x);
        if (x[62:0] == 0) return 64'h8000_0000_0000_0000;
        if (x[63])        return ~x;
        return x | 64'h8000_0000_0000_0000;
    endfunction

    function automatic void model(input logic [63:0] a, input logic [63:0] b_in,
                                  input logic sm, input logic zc,
                                  output logic [3:0] f, output logic inv);
        logic [63:0] b;
        b = zc ? 64'd0 : b_in;
        if (is_nan(a) || is_nan(b)) begin
            f   = 4'b0011;
            inv = sm || (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
        end else begin
            inv = 1'b0;
            if (okey(a) == okey(b))     f = 4'b0110;
            else if (okey(a) < okey(b)) f = 4'b1000;
            else                        f = 4'b0010;
        end
    endfunction

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic sm, input logic zc, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; sig_mode = sm; zero_cmp = zc;
        model(a, b, sm, zc, e.flags, e.inv);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: result is due after the rising edge following the drive
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (flags_o !== e.flags || invalid_o !== e.inv) begin
                    n_bad++;
                    $display("FAIL %s: flags=%b inv=%b expected flags=%b inv=%b",
                             e.tag, flags_o, invalid_o, e.flags, e.inv);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(posedge clk);
        #5;
        // R9: reset state
        n_cmp++;
        if (flags_o !== 4'b0000 || invalid_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: flags=%b inv=%b expected flags=0000 inv=0",
                     flags_o, invalid_o);
        end
        @(negedge clk);
        rst = 1'b0;

        drive(QNAN, P1, 1'b0, 1'b0, "R1 qnan a quiet");
        drive(P1, QNAN, 1'b0, 1'b0, "R1 qnan b quiet");
        drive(SNAN, P1, 1'b0, 1'b0, "R2 snan a quiet");
        drive(P2, SNAN, 1'b0, 1'b0, "R2 snan b quiet");
        drive(QNAN, QNAN, 1'b0, 1'b0, "R2 two qnans no invalid");
        drive(QNAN, P1, 1'b1, 1'b0, "R3 qnan signalling");
        drive(M1, QNAN | N0, 1'b1, 1'b0, "R3 neg qnan b signalling");
        drive(P1, P1, 1'b0, 1'b0, "R4 identical");
        drive(P0, N0, 1'b0, 1'b0, "R4 +0 vs -0");
        drive(PINF, PINF, 1'b1, 1'b0, "R4 inf equal signalling");
        drive(M1, P1, 1'b0, 1'b0, "R5 neg vs pos");
        drive(P2, M2, 1'b0, 1'b0, "R5 pos vs neg");
        drive(N0, DEN, 1'b0, 1'b0, "R5 -0 vs denormal");
        drive(P1, P2, 1'b0, 1'b0, "R6 1 < 2");
        drive(PINF, P2, 1'b0, 1'b0, "R6 inf > 2");
        drive(DEN, P0, 1'b0, 1'b0, "R6 denormal > 0");
        drive(M1, M2, 1'b0, 1'b0, "R7 -1 > -2");
        drive(MINF, M1, 1'b0, 1'b0, "R7 -inf < -1");
        drive(N0, P1, 1'b0, 1'b1, "R8 -0 vs forced zero");
        drive(M1, SNAN, 1'b0, 1'b1, "R8 snan b ignored");
        drive(P1, QNAN, 1'b1, 1'b1, "R8 qnan b ignored signalling");
        drive(SNAN, P1, 1'b0, 1'b1, "R8 snan a with zero");
        drive(M2, P2, 1'b1, 1'b0, "R10 ordered signalling");
        drive(PINF, MINF, 1'b1, 1'b0, "R10 infinities signalling");

        lfsr = 64'hACE1_2345_6789_BEEF;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            a = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            b = (i % 4 == 0) ? {a[63], a[62:8], lfsr[7:0]} : lfsr;
            if (i % 7 == 0) a[62:52] = 11'h7FF;
            drive(a, b, lfsr[3], (i % 9 == 0), "R6 R7 mixed sweep");
        end

        repeat (3) @(posedge clk);
        #6;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule